// File: doc/BRIEF.md
# Masked Condition-Register Field Logic Unit

This unit applies a bitwise lookup-table operation to one 4-bit field of a 32-bit condition register. The register is viewed as eight 4-bit fields. Three field selectors pick a destination field and two source fields. The destination field's current contents are also an operand of the lookup.

Two operations are provided. The ternary operation uses three bits as an index into an 8-bit immediate truth table: one bit each from the destination field and the two source fields. The dynamic binary operation uses two bits as an index, one from the destination and one from the first source field. It reads its 4-bit truth table from the second source field, so the function can be chosen at run time from register contents.

A 4-bit write mask decides which bits of the destination field take the new value. Bits that are not selected keep their old value. On a valid strobe the updated register value is captured into the output register in one clock. Decoding the instruction fields is the job of the surrounding pipeline.

Top module: `crl_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cr_o` becomes all zeros at that edge.
- R2: At an edge where `valid_i` is low and `rst` is low, `cr_o` keeps its value regardless of the other inputs.
- R3: CR bits are numbered with bit 0 as the MSB (vector bit 31). Field n occupies CR bits 4n to 4n+3, which are vector bits [31-4n -: 4]. Field bit k (vector order, k=3..0) is the lane governed by mask bit k and uses bit k of each operand field.
- R4: With `op_i`=0 (ternary), lane k computes the index j = {dst[k], srca[k], srcb[k]}, with dst as the MSB. The result is `imm_i[j]`, the immediate bit of weight 2^j.
- R5: With `op_i`=1 (binary), lane k computes the index j = {dst[k], srca[k]}. The result is bit j (weight 2^j) of the 4-bit table held in field `srcb_sel_i`.
- R6: When `mask_i[k]` is 0, bit k of the destination field in `cr_o` equals the same bit of `cr_i`. When it is 1, that bit takes the lane result.
- R7: On a valid update, every field other than `dst_sel_i` appears in `cr_o` exactly as in `cr_i`.
- R8: When the same index is given for two or all three selectors, every operand is read from `cr_i` before the update is applied.
- R9: A valid update with `mask_i`=0000 makes `cr_o` equal to `cr_i`.
- R10: In binary mode, `imm_i` has no effect on the result.
- R11: A valid update appears on `cr_o` after the first rising edge at which `valid_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Commit strobe for one operation |
| op_i | input | 1 | 0 = ternary immediate table, 1 = binary table from a field |
| dst_sel_i | input | 3 | Destination field index (also the first operand) |
| srca_sel_i | input | 3 | Second operand field index |
| srcb_sel_i | input | 3 | Third operand field (ternary) or table field (binary) |
| mask_i | input | 4 | Per-bit write enable for the destination field |
| imm_i | input | 8 | Ternary truth table |
| cr_i | input | 32 | Current condition-register value |
| cr_o | output | 32 | Registered updated condition-register value |

## Verification
Every result passes through a single register. A wrong field index, a swapped lane or a bad mask merge therefore shows up on `cr_o` in the cycle right after the strobe. A stale or wrongly held value shows up in the next idle cycle. Aliased selectors and an all-zero mask are driven on purpose, because an error that reads the destination after it has been written, or that writes under a zero mask, changes only a few bits. The bench compares the whole 32-bit output with its model after every edge, so one wrong bit is enough to report the fault.

// File: rtl/crl_pkg.sv
package crl_pkg;
   typedef enum logic {
      CRL_OP_TERN = 1'b0,
      CRL_OP_BIN  = 1'b1
   } crl_op_e;

   localparam int CRL_TERN_TBL_W = 8;
   localparam int CRL_BIN_TBL_W  = 4;
endpackage

// File: rtl/crl_field_pick.sv
module crl_field_pick #(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   localparam int CR_W      = FIELD_W * NUM_FIELDS,
   localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
   input  logic [CR_W-1:0]    cr_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic [FIELD_W-1:0] field_o
);
   logic [FIELD_W-1:0] fields [NUM_FIELDS];

   // field 0 sits at the most significant end of the register
   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slice
      assign fields[g] = cr_i[CR_W-1-FIELD_W*g -: FIELD_W];
   end

   assign field_o = fields[sel_i];
endmodule

// File: rtl/crl_lane_eval.sv
module crl_lane_eval
   import crl_pkg::*;
(
   input  logic                      dst_b_i,
   input  logic                      srca_b_i,
   input  logic                      srcb_b_i,
   input  crl_op_e                   op_i,
   input  logic [CRL_TERN_TBL_W-1:0] imm_i,
   input  logic [CRL_BIN_TBL_W-1:0]  tbl_i,
   output logic                      res_b_o
);
   logic [2:0] tern_idx;
   logic [1:0] bin_idx;

   assign tern_idx = {dst_b_i, srca_b_i, srcb_b_i};
   assign bin_idx  = {dst_b_i, srca_b_i};

   always_comb begin
      unique case (op_i)
         CRL_OP_BIN:  res_b_o = tbl_i[bin_idx];
         default:     res_b_o = imm_i[tern_idx];
      endcase
   end
endmodule

// File: rtl/crl_field_merge.sv
module crl_field_merge #(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   localparam int CR_W      = FIELD_W * NUM_FIELDS,
   localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
   input  logic [CR_W-1:0]    cr_i,
   input  logic [SEL_W-1:0]   dst_sel_i,
   input  logic [FIELD_W-1:0] new_field_i,
   input  logic [FIELD_W-1:0] mask_i,
   output logic [CR_W-1:0]    cr_o
);
   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      logic [FIELD_W-1:0] old_f;
      logic               hit;
      assign old_f = cr_i[CR_W-1-FIELD_W*g -: FIELD_W];
      assign hit   = (dst_sel_i == SEL_W'(g));
      assign cr_o[CR_W-1-FIELD_W*g -: FIELD_W] =
         hit ? ((new_field_i & mask_i) | (old_f & ~mask_i)) : old_f;
   end
endmodule

// File: rtl/crl_unit.sv
module crl_unit
   import crl_pkg::*;
#(
   parameter int FIELD_W    = 4,
   parameter int NUM_FIELDS = 8,
   localparam int CR_W      = FIELD_W * NUM_FIELDS,
   localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      valid_i,
   input  logic                      op_i,
   input  logic [SEL_W-1:0]          dst_sel_i,
   input  logic [SEL_W-1:0]          srca_sel_i,
   input  logic [SEL_W-1:0]          srcb_sel_i,
   input  logic [FIELD_W-1:0]        mask_i,
   input  logic [CRL_TERN_TBL_W-1:0] imm_i,
   input  logic [CR_W-1:0]           cr_i,
   output logic [CR_W-1:0]           cr_o
);
   // elaboration-time parameter checks
   if (FIELD_W < CRL_BIN_TBL_W) begin : g_bad_field_w
      $error("crl_unit: FIELD_W must hold a binary truth table");
   end
   if ((1 << SEL_W) != NUM_FIELDS || NUM_FIELDS < 2) begin : g_bad_num_fields
      $error("crl_unit: NUM_FIELDS must be a power of two >= 2");
   end

   logic [FIELD_W-1:0] dst_f, srca_f, srcb_f, res_f;
   logic [CR_W-1:0]    cr_next, cr_q;
   crl_op_e            op_sel;

   assign op_sel = crl_op_e'(op_i);

   crl_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_dst (
      .cr_i(cr_i), .sel_i(dst_sel_i), .field_o(dst_f));
   crl_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_srca (
      .cr_i(cr_i), .sel_i(srca_sel_i), .field_o(srca_f));
   crl_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_srcb (
      .cr_i(cr_i), .sel_i(srcb_sel_i), .field_o(srcb_f));

   for (genvar k = 0; k < FIELD_W; k++) begin : g_lane
      crl_lane_eval u_lane (
         .dst_b_i (dst_f[k]),
         .srca_b_i(srca_f[k]),
         .srcb_b_i(srcb_f[k]),
         .op_i    (op_sel),
         .imm_i   (imm_i),
         .tbl_i   (srcb_f[CRL_BIN_TBL_W-1:0]),
         .res_b_o (res_f[k])
      );
   end

   crl_field_merge #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_merge (
      .cr_i       (cr_i),
      .dst_sel_i  (dst_sel_i),
      .new_field_i(res_f),
      .mask_i     (mask_i),
      .cr_o       (cr_next)
   );

   always_ff @(posedge clk) begin
      if (rst)          cr_q <= '0;
      else if (valid_i) cr_q <= cr_next;
   end

   assign cr_o = cr_q;

   // checker-side masks built from ports by shifting, not from the merge path
   logic [CR_W-1:0] chk_fld_span, chk_wr_span;
   assign chk_fld_span = {{FIELD_W{1'b1}}, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(dst_sel_i));
   assign chk_wr_span  = {mask_i, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(dst_sel_i));

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> cr_q == '0);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(cr_q));

   // R7
   other_fields_kept_chk: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> ((cr_q ^ $past(cr_i)) & ~$past(chk_fld_span)) == '0);

   // R6
   masked_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> ((cr_q ^ $past(cr_i)) & ~$past(chk_wr_span)) == '0);

   // R9
   zero_mask_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_i && mask_i == '0) |=> cr_q == $past(cr_i));
endmodule

// File: tb/crl_unit_tb.sv
module crl_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        valid;
   logic        op;
   logic [2:0]  dsel, asel, bsel;
   logic [3:0]  mask;
   logic [7:0]  imm;
   logic [31:0] cr_in;
   logic [31:0] cr_out;

   logic [31:0] exp_q = '0;
   int          checks = 0;
   int          errors = 0;
   int          cycles = 0;
   bit          done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   crl_unit dut_i (
      .clk(clk), .rst(rst), .valid_i(valid), .op_i(op),
      .dst_sel_i(dsel), .srca_sel_i(asel), .srcb_sel_i(bsel),
      .mask_i(mask), .imm_i(imm), .cr_i(cr_in), .cr_o(cr_out));

   // behavioural reference: lanes numbered MSB-first as CR bits 4n+i
   function automatic logic [31:0] model(input logic [31:0] c, input logic o,
                                         input int d, input int a, input int b,
                                         input logic [3:0] m, input logic [7:0] t);
      logic [31:0] r = c;
      for (int i = 0; i < 4; i++) begin
         int pd = 31 - (4*d + i);
         int pa = 31 - (4*a + i);
         int pb = 31 - (4*b + i);
         int j;
         logic v;
         if (o == 1'b0) begin
            j = 4*int'(c[pd]) + 2*int'(c[pa]) + int'(c[pb]);
            v = t[j];
         end else begin
            j = 2*int'(c[pd]) + int'(c[pa]);
            v = c[31 - (4*b + 3 - j)];
         end
         if (m[3-i]) r[pd] = v;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst)        exp_q <= '0;
      else if (valid) exp_q <= model(cr_in, op, int'(dsel), int'(asel), int'(bsel), mask, imm);
   end

   task automatic step(input string tag, input logic r, input logic v, input logic o,
                       input int d, input int a, input int b,
                       input logic [3:0] m, input logic [7:0] t, input logic [31:0] c);
      rst = r; valid = v; op = o;
      dsel = 3'(d); asel = 3'(a); bsel = 3'(b);
      mask = m; imm = t; cr_in = c;
      @(negedge clk);
      checks++;
      if (cr_out !== exp_q) begin
         errors++;
         $display("FAIL %s: cr_o=%h expected=%h", tag, cr_out, exp_q);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL R11: watchdog expired, cycles=%0d expected<=100000", cycles);
         finish_run();
      end
   end

   localparam logic [31:0] PAT = 32'h0123_4567;

   initial begin
      // R1: reset clears the output
      step("R1 reset", 1, 1, 0, 0, 1, 2, 4'hF, 8'hFF, 32'hFFFF_FFFF);
      step("R1 reset", 1, 0, 0, 0, 0, 0, 4'h0, 8'h00, 32'hDEAD_BEEF);
      // R2: idle cycles hold
      step("R2 idle", 0, 0, 0, 3, 1, 2, 4'hF, 8'h96, 32'hA5A5_5A5A);
      // R11: single-cycle commit, R3 field placement (imm CC copies srca)
      step("R3 R11 copy field5->2", 0, 1, 0, 2, 5, 7, 4'hF, 8'hCC, PAT);
      step("R2 idle after op", 0, 0, 1, 6, 6, 6, 4'hF, 8'h00, 32'h0);
      step("R3 copy field0->7", 0, 1, 0, 7, 0, 1, 4'hF, 8'hCC, 32'hB000_0000);
      // R4: three-input functions
      step("R4 xor3", 0, 1, 0, 1, 3, 6, 4'hF, 8'h96, 32'h0F5A_3C69);
      step("R4 mux", 0, 1, 0, 4, 2, 5, 4'hF, 8'hD8, 32'h9C3A_65F0);
      step("R4 and3", 0, 1, 0, 0, 1, 2, 4'hF, 8'h80, 32'hEDB0_0000);
      step("R4 constant one", 0, 1, 0, 5, 5, 5, 4'hF, 8'hFF, 32'h0);
      // R5: table from a field
      step("R5 nand table", 0, 1, 1, 2, 3, 4, 4'hF, 8'h00, 32'h11C5_7000);
      step("R5 xor table", 0, 1, 1, 6, 1, 0, 4'hF, 8'h00, 32'h6A00_0090);
      // R10: immediate ignored in binary mode (same operands, two immediates)
      step("R10 imm 00", 0, 1, 1, 3, 6, 7, 4'hF, 8'h00, 32'h1234_5A96);
      step("R10 imm FF", 0, 1, 1, 3, 6, 7, 4'hF, 8'hFF, 32'h1234_5A96);
      step("R10 imm 5A", 0, 1, 1, 3, 6, 7, 4'hF, 8'h5A, 32'h1234_5A96);
      // R6 / R7: partial masks
      step("R6 mask 1010", 0, 1, 0, 3, 0, 1, 4'hA, 8'hFF, 32'h5500_0000);
      step("R6 mask 0001", 0, 1, 0, 6, 2, 4, 4'h1, 8'h00, 32'hFFFF_FFFF);
      step("R7 neighbours kept", 0, 1, 1, 0, 7, 7, 4'hF, 8'h00, 32'h0FFF_FFF3);
      // R8: aliased selectors read the pre-update value
      step("R8 all same tern", 0, 1, 0, 4, 4, 4, 4'hF, 8'h01, 32'h0000_C000);
      step("R8 all same bin", 0, 1, 1, 1, 1, 1, 4'hF, 8'h00, 32'h0600_0000);
      step("R8 dst as table", 0, 1, 1, 2, 5, 2, 4'hF, 8'h00, 32'h00B0_0A00);
      // R9: zero mask passes cr_i through
      step("R9 zero mask", 0, 1, 0, 2, 3, 4, 4'h0, 8'hFF, 32'hCAFE_F00D);
      step("R9 zero mask bin", 0, 1, 1, 7, 0, 0, 4'h0, 8'h00, 32'h1357_9BDF);
      // R1 again mid-run
      step("R1 reset mid-run", 1, 1, 0, 0, 0, 0, 4'hF, 8'hFF, 32'hFFFF_FFFF);
      // mixed random traffic, every requirement compared each cycle
      for (int n = 0; n < 400; n++) begin
         step("R2 R4 R5 R6 R7 random", ($urandom_range(0, 49) == 0),
              ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
              $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
              4'($urandom), 8'($urandom), $urandom);
      end
      finish_run();
   end
endmodule